// File: doc/BRIEF.md
# Confidence-Gated Load Value Predictor

This block guesses the data a load will return, so that work depending on that load can start before the memory system answers. A direct-mapped table, selected by the load's instruction address, holds for each load a small set of learned values, the last value actually seen and a stride. Last value plus stride is one more candidate. Every candidate carries its own saturating confidence counter.

A lookup presents the instruction address. One cycle later the block names the candidate with the highest confidence and its value. It raises a valid flag only when that confidence has reached a fixed threshold. When the real data arrives, the pipeline trains the block with the address, the true value and the candidate index it was given. The block updates the entry. If the caller marks the load as one that used the prediction, the block also reports whether that prediction was wrong.

Top module: `lvp_top`

## Requirements
- R1: After a synchronous active-high reset, every entry is empty. An empty entry behaves as all values, counters, last value and stride equal to zero. pred_valid, pred_value, pred_cand, chk_valid and chk_miss are all 0.
- R2: A lookup presented in cycle t produces its result in cycle t+1. In any cycle not following a lookup, pred_valid, pred_value and pred_cand are 0.
- R3: pred_valid is 1 only when the best candidate's counter is at least 12 (counters range 0..31). Otherwise pred_value and pred_cand are driven 0.
- R4: The best candidate has the highest counter. Ties go to the lowest index. Indices 0..4 are the learned values, and index 5 is last value plus stride.
- R5: The candidate at index 5 predicts last value plus stride, modulo 2^32.
- R6: For a training with tr_used=1, chk_valid is 1 in the next cycle. chk_miss is then 1 when the entry's candidate named by tr_cand, read before the update, differs from tr_value. An index of 6 or 7 always counts as a miss.
- R7: On training, each candidate whose value equals the true value gains 2, saturating at 31. Every other candidate loses 1, stopping at 0.
- R8: If no candidate matches, the learned value with the lowest counter (lowest index on ties) is overwritten by the true value, and its counter is set to 0.
- R9: Every training sets the stride to the true value minus the previous last value, and then sets the last value to the true value.
- R10: A lookup and a training in the same cycle on the same entry give the lookup the entry's state from before that training.
- R11: The entry is selected by address bits [7:2]. Addresses that agree in those bits share one entry.
- R12: A training with tr_used=0 updates the entry but leaves chk_valid and chk_miss at 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Instruction address of the load being looked up |
| tr_valid | input | 1 | Training request |
| tr_addr | input | 32 | Instruction address of the load being trained |
| tr_value | input | 32 | Value the load actually returned |
| tr_cand | input | 3 | Candidate index that was handed out for this load |
| tr_used | input | 1 | The prediction was consumed and must be checked |
| pred_valid | output | 1 | Confident prediction available |
| pred_value | output | 32 | Predicted load value |
| pred_cand | output | 3 | Index of the chosen candidate |
| chk_valid | output | 1 | Misprediction check result available |
| chk_miss | output | 1 | The used prediction was wrong |

## Verification
A behavioural reference model predicts every output on every clock. The stimulus starts with a load that always returns the same constant. Its counters climb through 10 and 12, which pins down the threshold and the climb to saturation. An arithmetic sequence on another load tells the stride candidate apart from the learned ones. A stream of fresh values then exposes the replacement order. Values that alternate between two numbers create counter ties, which resolve the tie-break. Forced bad indices, unused predictions, aliasing addresses and a random stream drawn from a small value set separate the check flag and the entry selection from the table's training.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  localparam int unsigned LVP_AW      = 32;
  localparam int unsigned LVP_DW      = 32;
  localparam int unsigned LVP_ENTRIES = 64;
  localparam int unsigned LVP_NLEARN  = 5;
  localparam int unsigned LVP_CONF_W  = 5;
  localparam int unsigned LVP_THRESH  = 12;
  localparam int unsigned LVP_IDX_LSB = 2;
endpackage

// File: rtl/lvp_pick.sv
module lvp_pick #(
  parameter int unsigned NUM      = 6,
  parameter int unsigned CW       = 5,
  parameter int unsigned IW       = 3,
  parameter bit          PICK_MAX = 1'b1
) (
  input  logic [NUM*CW-1:0] conf_flat,
  output logic [IW-1:0]     sel,
  output logic [CW-1:0]     sel_conf
);
  generate
    if (PICK_MAX) begin : g_max
      always_comb begin
        sel      = '0;
        sel_conf = conf_flat[CW-1:0];
        for (int i = 1; i < NUM; i++) begin
          if (conf_flat[i*CW +: CW] > sel_conf) begin
            sel      = IW'(i);
            sel_conf = conf_flat[i*CW +: CW];
          end
        end
      end
    end else begin : g_min
      always_comb begin
        sel      = '0;
        sel_conf = conf_flat[CW-1:0];
        for (int i = 1; i < NUM; i++) begin
          if (conf_flat[i*CW +: CW] < sel_conf) begin
            sel      = IW'(i);
            sel_conf = conf_flat[i*CW +: CW];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lvp_train.sv
module lvp_train #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NLEARN = 5,
  parameter int unsigned CONF_W = 5,
  parameter int unsigned IW     = 3,
  localparam int unsigned NC       = NLEARN + 1,
  localparam int unsigned CONF_OFF = NLEARN * DW,
  localparam int unsigned LAST_OFF = CONF_OFF + NC * CONF_W,
  localparam int unsigned STR_OFF  = LAST_OFF + DW,
  localparam int unsigned ENT_W    = STR_OFF + DW
) (
  input  logic [ENT_W-1:0] ent_in,
  input  logic [DW-1:0]    actual,
  input  logic [IW-1:0]    cand,
  output logic [ENT_W-1:0] ent_out,
  output logic             miss
);
  localparam logic [CONF_W-1:0] CMAX = {CONF_W{1'b1}};

  logic [DW-1:0]     last_v, stride_v, stride_cand, chosen;
  logic [NC-1:0]     match;
  logic              any_match;
  logic [IW-1:0]     victim;
  logic [CONF_W-1:0] victim_conf;

  assign last_v      = ent_in[LAST_OFF +: DW];
  assign stride_v    = ent_in[STR_OFF +: DW];
  assign stride_cand = last_v + stride_v;
  assign any_match   = |match;

  lvp_pick #(.NUM(NLEARN), .CW(CONF_W), .IW(IW), .PICK_MAX(1'b0)) u_victim (
    .conf_flat(ent_in[CONF_OFF +: NLEARN*CONF_W]),
    .sel      (victim),
    .sel_conf (victim_conf)
  );

  generate
    for (genvar i = 0; i < NLEARN; i++) begin : g_learn
      logic [CONF_W-1:0] c;
      assign c        = ent_in[CONF_OFF + i*CONF_W +: CONF_W];
      assign match[i] = (ent_in[i*DW +: DW] == actual);
      assign ent_out[i*DW +: DW] =
        (!any_match && victim == IW'(i)) ? actual : ent_in[i*DW +: DW];
      assign ent_out[CONF_OFF + i*CONF_W +: CONF_W] =
        match[i]                          ? ((c > CMAX - 2) ? CMAX : c + 2) :
        (!any_match && victim == IW'(i))  ? '0 :
        (c == '0)                         ? '0 : c - 1;
    end
  endgenerate

  logic [CONF_W-1:0] cs;
  assign cs            = ent_in[CONF_OFF + NLEARN*CONF_W +: CONF_W];
  assign match[NLEARN] = (stride_cand == actual);
  assign ent_out[CONF_OFF + NLEARN*CONF_W +: CONF_W] =
    match[NLEARN] ? ((cs > CMAX - 2) ? CMAX : cs + 2) :
    (cs == '0)    ? '0 : cs - 1;

  assign ent_out[LAST_OFF +: DW] = actual;
  assign ent_out[STR_OFF +: DW]  = actual - last_v;

  always_comb begin
    chosen = stride_cand;
    for (int i = 0; i < NLEARN; i++)
      if (cand == IW'(i)) chosen = ent_in[i*DW +: DW];
    miss = (int'(cand) >= int'(NC)) || (chosen != actual);
  end
endmodule

// File: rtl/lvp_top.sv
module lvp_top #(
  parameter int unsigned AW      = lvp_pkg::LVP_AW,
  parameter int unsigned DW      = lvp_pkg::LVP_DW,
  parameter int unsigned ENTRIES = lvp_pkg::LVP_ENTRIES,
  parameter int unsigned NLEARN  = lvp_pkg::LVP_NLEARN,
  parameter int unsigned CONF_W  = lvp_pkg::LVP_CONF_W,
  parameter int unsigned THRESH  = lvp_pkg::LVP_THRESH,
  parameter int unsigned IDX_LSB = lvp_pkg::LVP_IDX_LSB,
  localparam int unsigned NC       = NLEARN + 1,
  localparam int unsigned CIW      = $clog2(NC),
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned CONF_OFF = NLEARN * DW,
  localparam int unsigned LAST_OFF = CONF_OFF + NC * CONF_W,
  localparam int unsigned STR_OFF  = LAST_OFF + DW,
  localparam int unsigned ENT_W    = STR_OFF + DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lk_valid,
  input  logic [AW-1:0]  lk_addr,
  input  logic           tr_valid,
  input  logic [AW-1:0]  tr_addr,
  input  logic [DW-1:0]  tr_value,
  input  logic [CIW-1:0] tr_cand,
  input  logic           tr_used,
  output logic           pred_valid,
  output logic [DW-1:0]  pred_value,
  output logic [CIW-1:0] pred_cand,
  output logic           chk_valid,
  output logic           chk_miss
);
  logic [ENT_W-1:0]   mem [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [IDX_W-1:0]   lidx, tidx, wr_idx_q;
  logic [ENT_W-1:0]   rd_ent, rd_eff, tr_ent, new_ent;
  logic               rd_v, lk_q, tr_miss, hit;
  logic [CIW-1:0]     best_sel;
  logic [CONF_W-1:0]  best_conf;
  logic [DW-1:0]      best_val;

  assign lidx = lk_addr[IDX_LSB +: IDX_W];
  assign tidx = tr_addr[IDX_LSB +: IDX_W];

  // table write port and registered lookup read port (read-before-write)
  always_ff @(posedge clk) begin
    if (tr_valid) mem[tidx] <= new_ent;
    rd_ent   <= mem[lidx];
    wr_idx_q <= tidx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rd_v      <= 1'b0;
      lk_q      <= 1'b0;
      chk_valid <= 1'b0;
      chk_miss  <= 1'b0;
    end else begin
      if (tr_valid) vld[tidx] <= 1'b1;
      rd_v      <= vld[lidx];
      lk_q      <= lk_valid;
      chk_valid <= tr_valid && tr_used;
      chk_miss  <= tr_valid && tr_used && tr_miss;
    end
  end

  // lookup side
  assign rd_eff = rd_v ? rd_ent : '0;

  lvp_pick #(.NUM(NC), .CW(CONF_W), .IW(CIW), .PICK_MAX(1'b1)) u_best (
    .conf_flat(rd_eff[CONF_OFF +: NC*CONF_W]),
    .sel      (best_sel),
    .sel_conf (best_conf)
  );

  always_comb begin
    best_val = rd_eff[LAST_OFF +: DW] + rd_eff[STR_OFF +: DW];
    for (int i = 0; i < NLEARN; i++)
      if (best_sel == CIW'(i)) best_val = rd_eff[i*DW +: DW];
  end

  assign hit        = lk_q && (best_conf >= CONF_W'(THRESH));
  assign pred_valid = hit;
  assign pred_value = hit ? best_val : '0;
  assign pred_cand  = hit ? best_sel : '0;

  // training side
  assign tr_ent = vld[tidx] ? mem[tidx] : '0;

  lvp_train #(.DW(DW), .NLEARN(NLEARN), .CONF_W(CONF_W), .IW(CIW)) u_train (
    .ent_in (tr_ent),
    .actual (tr_value),
    .cand   (tr_cand),
    .ent_out(new_ent),
    .miss   (tr_miss)
  );

  // R2: a result only appears one cycle after a lookup
  p_lookup_latency_r2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(lk_valid));
  // R4: chosen index is a real candidate
  p_cand_range_r4: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (int'(pred_cand) <= int'(NLEARN)));
  // R6: check result follows a used training by one cycle
  p_check_latency_r6: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> $past(tr_valid && tr_used));
  // R12: a miss is only reported with a valid check
  p_miss_qualified_r12: assert property (@(posedge clk) disable iff (rst)
    chk_miss |-> chk_valid);
  // R9: the trained entry remembers the true value as its last value
  p_last_written_r9: assert property (@(posedge clk) disable iff (rst)
    tr_valid |=> (mem[wr_idx_q][LAST_OFF +: DW] == $past(tr_value)));
endmodule

// File: tb/tb_lvp_top.sv
module tb_lvp_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT = 64;
  localparam int N_L   = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, tr_valid, tr_used;
  logic [31:0] lk_addr, tr_addr, tr_value;
  logic [2:0]  tr_cand;
  logic        pred_valid, chk_valid, chk_miss;
  logic [31:0] pred_value;
  logic [2:0]  pred_cand;

  lvp_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string phase = "R1";

  logic [31:0] m_val [N_ENT][N_L];
  int          m_conf[N_ENT][N_L+1];
  logic [31:0] m_last[N_ENT], m_str[N_ENT];
  bit          m_vld [N_ENT];

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int ent_of(logic [31:0] a);
    return int'(a[7:2]);
  endfunction

  task automatic model_clear();
    for (int e = 0; e < N_ENT; e++) begin
      m_vld[e] = 0; m_last[e] = 0; m_str[e] = 0;
      for (int i = 0; i < N_L; i++) m_val[e][i] = 0;
      for (int i = 0; i <= N_L; i++) m_conf[e][i] = 0;
    end
  endtask

  function automatic logic [31:0] cand_val(int e, int c);
    if (c < N_L) return m_val[e][c];
    return m_last[e] + m_str[e];
  endfunction

  task automatic model_lookup(logic [31:0] a, output bit pv, output logic [31:0] v, output int c);
    int e = ent_of(a);
    int best = 0;
    for (int i = 1; i <= N_L; i++) if (m_conf[e][i] > m_conf[e][best]) best = i;
    pv = m_conf[e][best] >= 12;
    v = pv ? cand_val(e, best) : 32'h0;
    c = pv ? best : 0;
  endtask

  task automatic model_train(logic [31:0] a, logic [31:0] val, int cand, output bit miss);
    int e = ent_of(a);
    bit mt[N_L+1];
    bit any = 0;
    int vic = 0;
    miss = (cand > N_L) || (cand_val(e, cand) != val);
    for (int i = 0; i <= N_L; i++) begin
      mt[i] = (cand_val(e, i) == val);
      any |= mt[i];
    end
    for (int i = 1; i < N_L; i++) if (m_conf[e][i] < m_conf[e][vic]) vic = i;
    for (int i = 0; i <= N_L; i++) begin
      if (mt[i]) m_conf[e][i] = (m_conf[e][i] + 2 > 31) ? 31 : m_conf[e][i] + 2;
      else if (!any && i == vic) m_conf[e][i] = 0;
      else if (m_conf[e][i] > 0) m_conf[e][i] = m_conf[e][i] - 1;
    end
    if (!any) m_val[e][vic] = val;
    m_str[e]  = val - m_last[e];
    m_last[e] = val;
    m_vld[e]  = 1;
  endtask

  task automatic step(bit lv, logic [31:0] la, bit tv, logic [31:0] ta,
                      logic [31:0] tval, int tc, bit tu);
    bit epv, emiss;
    logic [31:0] ev;
    int ec;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; tr_valid = tv; tr_addr = ta;
    tr_value = tval; tr_cand = 3'(tc); tr_used = tu;
    if (lv) model_lookup(la, epv, ev, ec);
    else begin epv = 0; ev = 0; ec = 0; end
    emiss = 0;
    if (tv) model_train(ta, tval, tc, emiss);
    @(posedge clk);
    #1;
    check(phase, "pred_valid", 32'(pred_valid), 32'(epv));
    check(phase, "pred_value", pred_value, ev);
    check(phase, "pred_cand",  32'(pred_cand), 32'(ec));
    check(phase, "chk_valid",  32'(chk_valid), 32'(tv && tu));
    check(phase, "chk_miss",   32'(chk_miss), 32'(tv && tu && emiss));
  endtask

  // train and look up the same load in one cycle (R10 ordering)
  task automatic lt(logic [31:0] a, logic [31:0] v);
    step(1, a, 1, a, v, 0, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++; n_checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; lk_valid = 0; tr_valid = 0; tr_used = 0;
    lk_addr = 0; tr_addr = 0; tr_value = 0; tr_cand = 0;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    phase = "R1";
    check(phase, "pred_valid reset", 32'(pred_valid), 0);
    check(phase, "chk_valid reset",  32'(chk_valid), 0);
    check(phase, "chk_miss reset",   32'(chk_miss), 0);
    @(negedge clk); rst = 0;

    phase = "R2";
    step(1, 32'h40, 0, 0, 0, 0, 0);
    step(0, 32'h40, 0, 0, 0, 0, 0);

    // constant load: counters climb past the threshold
    phase = "R3";
    for (int k = 0; k < 9; k++) begin
      lt(32'h40, 32'h1234);
      step(1, 32'h40, 0, 0, 0, 0, 0);
    end
    phase = "R7";
    for (int k = 0; k < 14; k++) lt(32'h40, 32'h1234);
    step(1, 32'h40, 0, 0, 0, 0, 0);

    phase = "R5";
    for (int k = 0; k < 14; k++) begin
      lt(32'h80, 32'd100 + 32'(7*k));
      step(1, 32'h80, 0, 0, 0, 0, 0);
    end
    phase = "R5";
    for (int k = 0; k < 3; k++) lt(32'h84, 32'hFFFF_FFF0 + 32'(8*k));

    phase = "R8";
    for (int k = 0; k < 8; k++) begin
      step(1, 32'h40, 1, 32'h40, 32'h500 + 32'(k), 0, 1);
      step(1, 32'h40, 0, 0, 0, 0, 0);
    end

    phase = "R4";
    for (int k = 0; k < 20; k++) begin
      lt(32'hC0, (k % 2 == 0) ? 32'hAAAA : 32'h5555);
      step(1, 32'hC0, 0, 0, 0, 0, 0);
    end

    phase = "R6";
    for (int k = 0; k < 8; k++) step(1, 32'h80, 1, 32'h80, 32'd198 + 32'(7*k), k % 8, 1);
    step(0, 0, 1, 32'h40, 32'h1234, 7, 1);
    step(0, 0, 1, 32'h40, 32'h1234, 6, 1);

    phase = "R12";
    for (int k = 0; k < 4; k++) step(1, 32'h80, 1, 32'h80, 32'h77, 5, 0);

    phase = "R11";
    for (int k = 0; k < 8; k++) lt(32'h48, 32'h99);
    step(1, 32'h148, 0, 0, 0, 0, 0);
    step(1, 32'hFFFF_FF48, 1, 32'h1048, 32'h99, 0, 1);
    step(1, 32'h48, 0, 0, 0, 0, 0);

    phase = "R9";
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a = 32'(($urandom % 4) * 4) + 32'h200;
      step($urandom % 2 == 1, 32'(($urandom % 4) * 4) + 32'h200,
           $urandom % 4 != 0, a, 32'($urandom % 3), int'($urandom % 8), $urandom % 2 == 1);
    end

    phase = "R10";
    for (int k = 0; k < 10; k++) lt(32'hF0, 32'h3C);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule